// File: doc/BRIEF.md
# Read-Sequence Unlocked Write-Protect Gate

This block sits in the write-enable path between a host and a static RAM. The RAM address space is split into sixteen partitions, and a 16-bit protect mask says which of them may be written. The active-low write enable from the host passes through a register to the RAM unless the addressed partition is marked protected. In that case the RAM write enable is held inactive (high).

The mask has no write port. It is loaded by a run of read cycles that the block watches on a 4-bit address nibble. Twenty consecutive reads must present a fixed secret series of nibbles. The next four reads then carry the sixteen mask bits, four per read. Data that the RAM returns during this run has no meaning. The block ignores RAM data entirely.

The mask has no defined power-up value, so software must load it before it relies on protection.

Top module: `wprot_gate`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ram_we_n` is 1, whatever `host_we_n` is. Reset also returns the unlock matcher to its idle step.
- R2: `ram_we_n` is a register. It takes the value of `host_we_n` one clock later when the partition addressed in that earlier cycle is not protected.
- R3: The unlock series is 20 reads whose nibbles, in hex, are F,E,7,7,3,9,C,E,7,3,9,4,2,4,A,6,9,1,0,5. After that series, four more reads load the mask.
- R4: Nibble value `nib` = {line3,line2,line1,line0}. On data read k (k = 0..3, i.e. the 21st to 24th read), bit j of the nibble becomes mask bit 4k+j.
- R5: A mask bit of 1 keeps `ram_we_n` at 1 while `host_we_n` is 0. A mask bit of 0 lets the low pass through.
- R6: The partition of an access is the binary value of `nib` (0..15). It selects the mask bit with that index.
- R7: A read whose nibble differs from the expected pattern nibble aborts the run. The matcher restarts at step 1 when that nibble is F (the first pattern nibble), and at step 0 otherwise.
- R8: Any cycle with `host_we_n` low returns the matcher to step 0, whether or not `rd_stb` is high.
- R9: The 16 mask bits are replaced together when the fourth data read is taken. A data phase that is cut short leaves the previous mask unchanged.
- R10: The matcher moves at most one step per `rd_stb` pulse. Nibble changes in cycles without `rd_stb` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle pulse marking a host read cycle |
| nib | input | 4 | Address nibble: partition number and unlock symbol |
| host_we_n | input | 1 | Active-low write enable from the host |
| ram_we_n | output | 1 | Registered active-low write enable to the RAM |

## Verification
The bench builds the block with its default parameters: a 4-bit nibble, a 20-step series and four data reads. With these values every one of the sixteen partitions can be probed after each load, and whole-mask patterns (all clear, all set, mixed, a single bit) can be tried in a short run.

The short series also makes it cheap to reach the abort cases:
- a mismatch partway through the series,
- a restart on the first pattern nibble,
- a write inside the series,
- a data phase cut short after two reads.

Reads are spaced with noise cycles, so the no-strobe behaviour is exercised on every load.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int NIB_W    = 4;
  localparam int PAT_LEN  = 20;
  localparam int NPART    = 1 << NIB_W;
  localparam int DATA_CYC = NPART / NIB_W;

  typedef logic [NIB_W-1:0] nib_t;

  // Secret unlock series; index 0 is the first read.
  function automatic nib_t unlock_nib(input int idx);
    case (idx)
      0:  return 4'hF;
      1:  return 4'hE;
      2:  return 4'h7;
      3:  return 4'h7;
      4:  return 4'h3;
      5:  return 4'h9;
      6:  return 4'hC;
      7:  return 4'hE;
      8:  return 4'h7;
      9:  return 4'h3;
      10: return 4'h9;
      11: return 4'h4;
      12: return 4'h2;
      13: return 4'h4;
      14: return 4'hA;
      15: return 4'h6;
      16: return 4'h9;
      17: return 4'h1;
      18: return 4'h0;
      19: return 4'h5;
      default: return 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/wpg_seq_match.sv
module wpg_seq_match #(
  parameter int NIB_W    = wpg_pkg::NIB_W,
  parameter int PAT_LEN  = wpg_pkg::PAT_LEN,
  parameter int DATA_CYC = wpg_pkg::DATA_CYC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_stb,
  input  logic                host_we_n,
  input  logic [NIB_W-1:0]    nib,
  output logic                data_vld,
  output logic [$clog2(DATA_CYC > 1 ? DATA_CYC : 2)-1:0] data_idx,
  output logic                commit
);
  localparam int SEQ_LEN = PAT_LEN + DATA_CYC;
  localparam int STEP_W  = $clog2(SEQ_LEN + 1);
  localparam int IDX_W   = $clog2(DATA_CYC > 1 ? DATA_CYC : 2);

  logic [STEP_W-1:0] step, step_nx;
  logic              adv, in_data, hit, hit_first;
  logic [NIB_W-1:0]  want;

  always_comb begin
    want      = wpg_pkg::unlock_nib(int'(step));
    adv       = rd_stb && host_we_n;
    in_data   = step >= STEP_W'(PAT_LEN);
    hit       = (nib == want);
    hit_first = (nib == wpg_pkg::unlock_nib(0));
    data_vld  = adv && in_data;
    data_idx  = IDX_W'(step - STEP_W'(PAT_LEN));
    commit    = data_vld && (step == STEP_W'(SEQ_LEN - 1));
  end

  always_comb begin
    step_nx = step;
    if (!host_we_n)       step_nx = '0;
    else if (adv) begin
      if (in_data)        step_nx = commit ? '0 : step + 1'b1;
      else if (hit)       step_nx = step + 1'b1;
      else if (hit_first) step_nx = STEP_W'(1);
      else                step_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step <= '0;
    else     step <= step_nx;
  end

  a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
    !host_we_n |=> step == '0);
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (host_we_n && !rd_stb) |=> $stable(step));
  a_r7_restart_on_first: assert property (@(posedge clk) disable iff (rst)
    (adv && !in_data && !hit && hit_first) |=> step == STEP_W'(1));
  a_r3_step_bound: assert property (@(posedge clk) disable iff (rst)
    step < STEP_W'(SEQ_LEN));
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> step == '0);
endmodule

// File: rtl/wpg_prot_store.sv
module wpg_prot_store #(
  parameter int NIB_W    = wpg_pkg::NIB_W,
  parameter int DATA_CYC = wpg_pkg::DATA_CYC
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       data_vld,
  input  logic [$clog2(DATA_CYC > 1 ? DATA_CYC : 2)-1:0] data_idx,
  input  logic                       commit,
  input  logic [NIB_W-1:0]           nib,
  output logic [NIB_W*DATA_CYC-1:0]  prot
);
  localparam int NPART = NIB_W * DATA_CYC;
  localparam int IDX_W = $clog2(DATA_CYC > 1 ? DATA_CYC : 2);

  logic [NIB_W-1:0] shadow [DATA_CYC];
  logic [NPART-1:0] prot_nx;

  // Staging slots for all but the final data read; no reset (undefined at power-up).
  for (genvar k = 0; k < DATA_CYC; k++) begin : g_slot
    if (k < DATA_CYC - 1) begin : g_stage
      always_ff @(posedge clk) begin
        if (data_vld && data_idx == IDX_W'(k)) shadow[k] <= nib;
      end
      assign prot_nx[k*NIB_W +: NIB_W] = shadow[k];
    end else begin : g_last
      always_comb shadow[k] = nib;
      assign prot_nx[k*NIB_W +: NIB_W] = nib;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) prot <= prot_nx;
  end

  a_r9_mask_held: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(prot));
  a_r4_last_nibble: assert property (@(posedge clk) disable iff (rst)
    commit |=> prot[NPART-1 -: NIB_W] == $past(nib));
endmodule

// File: rtl/wpg_we_gate.sv
module wpg_we_gate #(
  parameter int NIB_W = wpg_pkg::NIB_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_we_n,
  input  logic [NIB_W-1:0]       nib,
  input  logic [(1<<NIB_W)-1:0]  prot,
  output logic                   ram_we_n
);
  logic blocked;
  assign blocked = prot[nib];

  always_ff @(posedge clk) begin
    if (rst) ram_we_n <= 1'b1;
    else     ram_we_n <= host_we_n | blocked;
  end

  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    host_we_n |=> ram_we_n);
  a_r5_blocked: assert property (@(posedge clk) disable iff (rst)
    (!host_we_n && blocked) |=> ram_we_n);
  a_r5_passed: assert property (@(posedge clk) disable iff (rst)
    (!host_we_n && !blocked) |=> !ram_we_n);
  a_r1_reset_high: assert property (@(posedge clk)
    rst |=> ram_we_n);
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int NIB_W   = wpg_pkg::NIB_W,
  parameter int PAT_LEN = wpg_pkg::PAT_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  logic [NIB_W-1:0] nib,
  input  logic             host_we_n,
  output logic             ram_we_n
);
  localparam int NPART    = 1 << NIB_W;
  localparam int DATA_CYC = NPART / NIB_W;
  localparam int IDX_W    = $clog2(DATA_CYC > 1 ? DATA_CYC : 2);

  logic             data_vld, commit;
  logic [IDX_W-1:0] data_idx;
  logic [NPART-1:0] prot;

  wpg_seq_match #(.NIB_W(NIB_W), .PAT_LEN(PAT_LEN), .DATA_CYC(DATA_CYC)) u_match (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .host_we_n(host_we_n), .nib(nib),
    .data_vld(data_vld), .data_idx(data_idx), .commit(commit)
  );

  wpg_prot_store #(.NIB_W(NIB_W), .DATA_CYC(DATA_CYC)) u_store (
    .clk(clk), .rst(rst), .data_vld(data_vld), .data_idx(data_idx),
    .commit(commit), .nib(nib), .prot(prot)
  );

  wpg_we_gate #(.NIB_W(NIB_W)) u_gate (
    .clk(clk), .rst(rst), .host_we_n(host_we_n), .nib(nib),
    .prot(prot), .ram_we_n(ram_we_n)
  );
endmodule

// File: tb/wprot_gate_test.sv
module wprot_gate_test;
  localparam int CLK_NS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_stb = 1'b0;
  logic [3:0] nib = 4'h0;
  logic       host_we_n = 1'b1;
  logic       ram_we_n;

  always #(CLK_NS/2) clk = ~clk;

  wprot_gate uut (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .nib(nib),
    .host_we_n(host_we_n), .ram_we_n(ram_we_n)
  );

  typedef struct {
    int    due;
    logic  exp;
    string tag;
    int    part;
  } item_t;

  item_t       sbq[$];
  int          edge_cnt = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [15:0] model = 16'h0;
  bit          done = 0;

  function automatic logic [3:0] pat(input int i);
    logic [3:0] t [20] = '{4'hF,4'hE,4'h7,4'h7,4'h3,4'h9,4'hC,4'hE,4'h7,4'h3,
                           4'h9,4'h4,4'h2,4'h4,4'hA,4'h6,4'h9,4'h1,4'h0,4'h5};
    return t[i];
  endfunction

  // Monitor: samples just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      edge_cnt++;
      while (sbq.size() > 0 && sbq[0].due == edge_cnt) begin
        item_t it;
        it = sbq.pop_front();
        n_cmp++;
        if (ram_we_n !== it.exp) begin
          n_bad++;
          $display("FAIL %s partition %0d: ram_we_n actual %b expected %b",
                   it.tag, it.part, ram_we_n, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] n);
    @(negedge clk);
    rd_stb = 1'b1; nib = n; host_we_n = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; nib = ~n ^ 4'h6;   // noise cycle without strobe (R10)
  endtask

  task automatic probe(input int p, input string tag);
    item_t it;
    @(negedge clk);
    host_we_n = 1'b0; rd_stb = 1'b0; nib = 4'(p);
    it.due = edge_cnt + 1; it.exp = model[p]; it.tag = tag; it.part = p;
    sbq.push_back(it);
    @(negedge clk);
    host_we_n = 1'b1;
  endtask

  task automatic idle_probe(input string tag);
    item_t it;
    @(negedge clk);
    host_we_n = 1'b1; rd_stb = 1'b0; nib = 4'h3;
    it.due = edge_cnt + 1; it.exp = 1'b1; it.tag = tag; it.part = 3;
    sbq.push_back(it);
  endtask

  task automatic send_pat(input int from, input int upto);
    for (int i = from; i < upto; i++) rd(pat(i));
  endtask

  task automatic send_data(input logic [15:0] v, input int cnt);
    for (int k = 0; k < cnt; k++) rd(v[4*k +: 4]);
  endtask

  task automatic load(input logic [15:0] v);
    send_pat(0, 20);
    send_data(v, 4);
    model = v;
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 16; p++) probe(p, tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: held low host enable during reset must not reach the RAM
    host_we_n = 1'b0;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (ram_we_n !== 1'b1) begin
      n_bad++; $display("FAIL R1 in reset: actual %b expected 1", ram_we_n);
    end
    rst = 1'b0; host_we_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (ram_we_n !== 1'b1) begin
      n_bad++; $display("FAIL R1 after reset: actual %b expected 1", ram_we_n);
    end

    // R3 R4 R5 R6: mixed mask, every partition
    load(16'hA5C3);  sweep("R3/R4/R6 mixed");
    idle_probe("R2 idle high");
    load(16'h0000);  sweep("R5 all writable");
    load(16'hFFFF);  sweep("R5 all protected");
    load(16'h0020);  sweep("R4 single bit 5");
    load(16'h8001);  sweep("R4 edge bits");

    // R7: mismatch at step 10 then continuing series must not load
    send_pat(0, 10); rd(4'hB); send_pat(11, 20); send_data(16'h1234, 4);
    sweep("R7 mismatch aborts");

    // R7: non-F mismatch drops to step 0; rest of series does not complete
    send_pat(0, 5); rd(4'h0); send_pat(1, 20); send_data(16'h5A5A, 4);
    sweep("R7 no restart");

    // R7: F mismatch restarts at step 1
    send_pat(0, 5); rd(4'hF); send_pat(1, 20); send_data(16'h3C96, 4);
    model = 16'h3C96;
    sweep("R7 restart on F");

    // R8: write inside series aborts
    send_pat(0, 10); probe(2, "R8 write mid series");
    send_pat(10, 20); send_data(16'hFFFF, 4);
    sweep("R8 series aborted");

    // R9: data phase cut short by a write leaves the old mask
    send_pat(0, 20); send_data(16'h0F0F, 2);
    probe(9, "R9 write in data phase");
    send_data(16'h0F0F, 2);
    sweep("R9 partial data ignored");

    // R10: strobe-free noise between every read (built into rd) still loads
    load(16'h6E11);  sweep("R10 noise between strobes");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule